// File: doc/BRIEF.md
# Multiphase Sampling TDC Channel

One channel of a 4-bit time-to-digital converter. A fast clock runs at eight times the bunch-crossing rate (Bx). Two 4-bit Johnson counters turn that clock into sixteen half-cycle phases per Bx. One counter steps on the rising edge. The other copies it on the falling edge. The rising edge of the hit input freezes both counters into an 8-bit capture register. A per-bin match table turns that pattern into a 4-bit fine time, the number of half fast-clock periods since the start of the Bx.

A capture is qualified in the half Bx that follows its arrival. Hits in the first half are qualified at the mid-Bx edge. Hits in the second half are qualified at the next Bx boundary. Every qualified hit is loaded into the output register at the middle of the Bx after the one it arrived in. The output then holds for exactly one Bx. While a capture waits to be qualified, the channel ignores further hit edges. Once a Bx has a qualified hit, later hits in that Bx are dropped. A Bx without a hit leaves no dead time.

Bx 0 begins at the last fast-clock edge that samples reset high. Slot p of Bx m spans fast-clock half periods 16m+p after that edge.

Top module: `tdc_channel`

## Requirements
- R1: A synchronous, active-high `rst_i` sampled at a rising `clk_i` edge sets `valid_o` to 0 and `time_o` to 0 after that edge. It also restarts the phase counters, so Bx 0 begins at the last edge that samples reset high.
- R2: A single hit whose rising edge falls in half-period slot p (0 to 15) of a Bx is reported with `time_o` = p.
- R3: A hit in slots 0 to 7 of Bx m appears at the `clk_i` edge that starts the fifth fast cycle of Bx m+1 (edge 8(m+1)+4 after Bx 0 starts). Before that edge, `valid_o` is 0.
- R4: A hit in slots 8 to 15 of Bx m appears at the same edge as in R3, the middle of Bx m+1.
- R5: `valid_o` and `time_o` change only at mid-Bx edges. A reported hit stays on the outputs for exactly 8 fast cycles. Whenever `valid_o` is 0, `time_o` reads 0.
- R6: Only the earliest hit of a Bx is reported. A later hit in the same Bx, in the same half or in the other half, produces no output.
- R7: A hit in the second half of Bx m does not block a hit in the first half of Bx m+1. Both are reported, in Bx m+1 and Bx m+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast clock at 8x the Bx rate |
| rst_i | input | 1 | Synchronous active-high reset, also aligns the Bx |
| hit_i | input | 1 | Hit; its rising edge captures the phase counters |
| valid_o | output | 1 | A hit is reported for the current Bx window |
| time_o | output | 4 | Fine time in half fast-clock periods, 0 when not valid |

## Verification
A hit in Bx m of either half is due at fast edge 8(m+1)+4 and leaves at edge 8(m+2)+4. The bench computes each hit's launch time and sampling times from the time of the last reset edge. It reads the outputs 3 ns before the due edge to confirm nothing arrives early, and 3 ns after it for the value. Hit pulses are offset 2 ns into a half period, so no capture coincides with a clock edge.

// File: rtl/tdc_pkg.sv
`timescale 1ns/1ps
package tdc_pkg;

   // Qualification points inside one bunch crossing
   typedef enum logic [1:0] {
      EDGE_NONE = 2'd0,
      EDGE_MID  = 2'd1,
      EDGE_END  = 2'd2
   } bx_edge_e;

   // State number k of a pb-bit Johnson ring: bit i is set when i < k <= i+pb
   function automatic logic [31:0] jstate(input int k, input int pb);
      logic [31:0] s;
      s = '0;
      for (int i = 0; i < 32; i++) begin
         if (i < pb && k > i && k <= i + pb) s[i] = 1'b1;
      end
      return s;
   endfunction

endpackage

// File: rtl/tdc_phase_gen.sv
`timescale 1ns/1ps
module tdc_phase_gen
   import tdc_pkg::*;
#(
   parameter int PB = 4
) (
   input  logic          clk_i,
   input  logic          rst_i,
   output logic [PB-1:0] rise_q_o,
   output logic [PB-1:0] fall_q_o,
   output bx_edge_e      edge_o
);
   localparam int NSTATE = 2 * PB;
   localparam logic [PB-1:0] S_ZERO   = PB'(jstate(0, PB));
   localparam logic [PB-1:0] S_PREMID = PB'(jstate(PB - 1, PB));
   localparam logic [PB-1:0] S_LAST   = PB'(jstate(NSTATE - 1, PB));

   logic [PB-1:0] rise_q;
   logic [PB-1:0] fall_q;

   // Rising-edge ring: shift left, feed back inverted MSB
   always_ff @(posedge clk_i) begin
      if (rst_i) rise_q <= S_ZERO;
      else       rise_q <= {rise_q[PB-2:0], ~rise_q[PB-1]};
   end

   // Falling-edge copy lags by half a fast period
   always_ff @(negedge clk_i) begin
      if (rst_i) fall_q <= S_LAST;
      else       fall_q <= rise_q;
   end

   always_comb begin
      if (rise_q == S_PREMID)    edge_o = EDGE_MID;
      else if (rise_q == S_LAST) edge_o = EDGE_END;
      else                       edge_o = EDGE_NONE;
   end

   assign rise_q_o = rise_q;
   assign fall_q_o = fall_q;
endmodule

// File: rtl/tdc_hit_capture.sv
`timescale 1ns/1ps
module tdc_hit_capture #(
   parameter int PW = 8
) (
   input  logic          hit_i,
   input  logic [PW-1:0] phase_i,
   input  logic          ack_tog_i,
   output logic [PW-1:0] pat_o,
   output logic          tog_o
);
   logic [PW-1:0] pat_q;
   logic          tog_q;
   logic          armed;

   // Armed only when the fast domain has consumed the previous capture
   assign armed = (tog_q == ack_tog_i);

   always_ff @(posedge hit_i) begin
      if (armed) begin
         pat_q <= phase_i;
         tog_q <= ~tog_q;
      end
   end

   assign pat_o = pat_q;
   assign tog_o = tog_q;
endmodule

// File: rtl/tdc_fine_decode.sv
`timescale 1ns/1ps
module tdc_fine_decode
   import tdc_pkg::*;
#(
   parameter int PB     = 4,
   parameter int TIME_W = 4
) (
   input  logic [2*PB-1:0]   pat_i,
   output logic [TIME_W-1:0] code_o,
   output logic              legal_o
);
   localparam int NSTATE = 2 * PB;
   localparam int NBINS  = 4 * PB;

   logic [NBINS-1:0] match;

   // One comparator per bin: rising ring at step b/2, falling ring equal (odd) or one step behind (even)
   for (genvar b = 0; b < NBINS; b++) begin : g_bin
      localparam int K  = b / 2;
      localparam int KP = (K + NSTATE - 1) % NSTATE;
      localparam logic [PB-1:0] RX = PB'(jstate(K, PB));
      localparam logic [PB-1:0] FX = (b % 2 == 1) ? RX : PB'(jstate(KP, PB));
      assign match[b] = (pat_i == {RX, FX});
   end

   always_comb begin
      code_o = '0;
      for (int b = 0; b < NBINS; b++) begin
         if (match[b]) code_o = code_o | TIME_W'(b);
      end
      legal_o = |match;
   end
endmodule

// File: rtl/tdc_channel.sv
`timescale 1ns/1ps
module tdc_channel
   import tdc_pkg::*;
#(
   parameter int PHASE_BITS = 4,
   localparam int NBINS     = 4 * PHASE_BITS,
   localparam int TIME_W    = $clog2(NBINS)
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              hit_i,
   output logic              valid_o,
   output logic [TIME_W-1:0] time_o
);
   localparam int HALF_BINS = NBINS / 2;

   if (PHASE_BITS < 2) begin : g_bad_pb
      $error("tdc_channel: PHASE_BITS must be at least 2");
   end
   if (PHASE_BITS > 16) begin : g_big_pb
      $error("tdc_channel: PHASE_BITS above 16 is not supported");
   end

   logic [PHASE_BITS-1:0]   rise_q;
   logic [PHASE_BITS-1:0]   fall_q;
   bx_edge_e                edge_kind;
   logic [2*PHASE_BITS-1:0] cap_pat;
   logic                    hit_tog;
   logic                    ack_tog;
   logic                    pend;
   logic [TIME_W-1:0]       cap_code;
   logic                    cap_legal;
   logic                    first_half;
   logic                    stage_v;
   logic [TIME_W-1:0]       stage_t;
   logic                    out_v;
   logic [TIME_W-1:0]       out_t;

   tdc_phase_gen #(.PB(PHASE_BITS)) u_gen (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .rise_q_o (rise_q),
      .fall_q_o (fall_q),
      .edge_o   (edge_kind)
   );

   tdc_hit_capture #(.PW(2 * PHASE_BITS)) u_cap (
      .hit_i     (hit_i),
      .phase_i   ({rise_q, fall_q}),
      .ack_tog_i (ack_tog),
      .pat_o     (cap_pat),
      .tog_o     (hit_tog)
   );

   tdc_fine_decode #(.PB(PHASE_BITS), .TIME_W(TIME_W)) u_dec (
      .pat_i   (cap_pat),
      .code_o  (cap_code),
      .legal_o (cap_legal)
   );

   assign pend       = hit_tog ^ ack_tog;
   assign first_half = (cap_code < TIME_W'(HALF_BINS));

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         ack_tog <= hit_tog;
         stage_v <= 1'b0;
         stage_t <= '0;
         out_v   <= 1'b0;
         out_t   <= '0;
      end else begin
         unique case (edge_kind)
            EDGE_MID: begin
               // Publish last Bx's result, qualify first-half capture of this Bx
               out_v   <= stage_v;
               out_t   <= stage_v ? stage_t : '0;
               stage_v <= 1'b0;
               if (pend && (first_half || !cap_legal)) begin
                  ack_tog <= ~ack_tog;
                  if (cap_legal) begin
                     stage_v <= 1'b1;
                     stage_t <= cap_code;
                  end
               end
            end
            EDGE_END: begin
               // Qualify second-half capture; dropped if the Bx already has a hit
               if (pend && (!first_half || !cap_legal)) begin
                  ack_tog <= ~ack_tog;
                  if (cap_legal && !stage_v) begin
                     stage_v <= 1'b1;
                     stage_t <= cap_code;
                  end
               end
            end
            default: ;
         endcase
      end
   end

   assign valid_o = out_v;
   assign time_o  = out_t;
endmodule

// File: rtl/tdc_channel_chk.sv
`timescale 1ns/1ps
module tdc_channel_chk #(
   parameter int PHASE_BITS = 4,
   localparam int TIME_W    = $clog2(4 * PHASE_BITS)
) (
   input logic                  clk_i,
   input logic                  rst_i,
   input logic                  valid_o,
   input logic [TIME_W-1:0]     time_o,
   input logic [PHASE_BITS-1:0] rise_q,
   input logic [PHASE_BITS-1:0] fall_q,
   input logic                  pend,
   input logic                  cap_legal
);
   localparam int NSTATE = 2 * PHASE_BITS;
   localparam int CW     = $clog2(NSTATE);
   localparam logic [CW-1:0] MID_PRE = CW'(PHASE_BITS - 1);

   // Own Bx position counter, independent of the Johnson rings
   logic [CW-1:0] cnt_q;
   always_ff @(posedge clk_i) begin
      if (rst_i)                           cnt_q <= '0;
      else if (cnt_q == CW'(NSTATE - 1))   cnt_q <= '0;
      else                                 cnt_q <= cnt_q + 1'b1;
   end

   // R1
   rst_clear_chk: assert property (@(posedge clk_i)
      rst_i |=> (!valid_o && time_o == '0));

   // R5
   out_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (cnt_q != MID_PRE) |=> ($stable(valid_o) && $stable(time_o)));

   // R5
   idle_zero_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      !valid_o |-> (time_o == '0));

   // R2
   ring_step_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      !$past(rst_i) |-> ($countones(rise_q ^ $past(rise_q)) == 1));

   // R2
   fall_lag_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      !$past(rst_i) |-> (fall_q == rise_q));

   // R2
   cap_legal_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      pend |-> cap_legal);
endmodule

bind tdc_channel tdc_channel_chk #(.PHASE_BITS(PHASE_BITS)) u_chk (
   .clk_i     (clk_i),
   .rst_i     (rst_i),
   .valid_o   (valid_o),
   .time_o    (time_o),
   .rise_q    (rise_q),
   .fall_q    (fall_q),
   .pend      (pend),
   .cap_legal (cap_legal)
);

// File: tb/tdc_channel_tb.sv
`timescale 1ns/1ps
module tdc_channel_tb;
   localparam int CLK_PERIOD = 10;
   localparam int PB         = 4;
   localparam int TW         = 4;
   localparam int BX         = CLK_PERIOD * 2 * PB;
   localparam int SLOT       = CLK_PERIOD / 2;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          hit = 1'b0;
   logic          valid;
   logic [TW-1:0] tm;

   int  n_chk = 0;
   int  n_err = 0;
   int  nb    = 1;
   time t0    = 0;
   bit  done  = 1'b0;

   tdc_channel #(.PHASE_BITS(PB)) u_dut (
      .clk_i   (clk),
      .rst_i   (rst),
      .hit_i   (hit),
      .valid_o (valid),
      .time_o  (tm)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   function automatic time at_slot(int bx, int slot);
      return t0 + time'(BX * bx + SLOT * slot + 2);
   endfunction

   function automatic time after_mid(int bx);
      return t0 + time'(BX * bx + BX / 2 + 3);
   endfunction

   function automatic time before_mid(int bx);
      return t0 + time'(BX * bx + BX / 2 - 3);
   endfunction

   task automatic wait_until(time t);
      if (t > $time) #(t - $time);
   endtask

   task automatic pulse_hit(int bx, int slot);
      wait_until(at_slot(bx, slot));
      hit = 1'b1;
      #1 hit = 1'b0;
   endtask

   task automatic check_now(string req, bit v_exp, int t_exp);
      n_chk++;
      if (valid !== v_exp || tm !== TW'(t_exp)) begin
         n_err++;
         $display("FAIL %s: valid_o=%0b time_o=%0d expected valid_o=%0b time_o=%0d",
                  req, valid, tm, v_exp, t_exp);
      end
   endtask

   task automatic expect_at(string req, time t, bit v_exp, int t_exp);
      wait_until(t);
      check_now(req, v_exp, t_exp);
   endtask

   task automatic do_reset();
      rst = 1'b1;
      repeat (4) @(posedge clk);
      t0 = $time;
      #1 rst = 1'b0;
      nb = 1;
   endtask

   // R1: outputs idle after reset
   task automatic t_reset_state();
      do_reset();
      expect_at("R1", t0 + 3, 1'b0, 0);
      expect_at("R1", after_mid(0), 1'b0, 0);
   endtask

   // R2, R3, R4: every slot, one hit per other Bx
   task automatic t_sweep();
      for (int p = 0; p < 4 * PB; p++) begin
         int b = nb + 2 * p;
         string req = (p < 2 * PB) ? "R2/R3" : "R2/R4";
         pulse_hit(b, p);
         expect_at(req, before_mid(b + 1), 1'b0, 0);
         expect_at(req, after_mid(b + 1), 1'b1, p);
      end
      nb = nb + 8 * PB + 1;
   endtask

   // R5: held one Bx, then cleared
   task automatic t_hold();
      int b = nb;
      pulse_hit(b, 4);
      expect_at("R5", after_mid(b + 1), 1'b1, 4);
      expect_at("R5", before_mid(b + 2), 1'b1, 4);
      expect_at("R5", after_mid(b + 2), 1'b0, 0);
      nb = b + 3;
   endtask

   // R6: earliest hit of a Bx wins
   task automatic t_earliest();
      int b = nb;
      pulse_hit(b, 3);
      pulse_hit(b, 12);
      expect_at("R6", after_mid(b + 1), 1'b1, 3);
      expect_at("R6", after_mid(b + 2), 1'b0, 0);
      b = b + 3;
      pulse_hit(b, 9);
      pulse_hit(b, 14);
      expect_at("R6", after_mid(b + 1), 1'b1, 9);
      expect_at("R6", after_mid(b + 2), 1'b0, 0);
      b = b + 3;
      pulse_hit(b, 1);
      pulse_hit(b, 5);
      expect_at("R6", after_mid(b + 1), 1'b1, 1);
      expect_at("R6", after_mid(b + 2), 1'b0, 0);
      nb = b + 3;
   endtask

   // R7: a late hit does not shadow the next Bx
   task automatic t_cross();
      int b = nb;
      pulse_hit(b, 13);
      pulse_hit(b + 1, 2);
      expect_at("R7", after_mid(b + 1), 1'b1, 13);
      expect_at("R7", after_mid(b + 2), 1'b1, 2);
      expect_at("R7", after_mid(b + 3), 1'b0, 0);
      b = b + 4;
      pulse_hit(b, 15);
      pulse_hit(b + 1, 0);
      expect_at("R7", after_mid(b + 1), 1'b1, 15);
      expect_at("R7", after_mid(b + 2), 1'b1, 0);
      nb = b + 4;
   endtask

   // R1: reset mid-run clears the output and realigns the Bx
   task automatic t_mid_reset();
      int b = nb;
      pulse_hit(b, 6);
      expect_at("R1", after_mid(b + 1), 1'b1, 6);
      wait_until(after_mid(b + 1) + 1);
      rst = 1'b1;
      @(posedge clk);
      #3 check_now("R1", 1'b0, 0);
      repeat (3) @(posedge clk);
      t0 = $time;
      #1 rst = 1'b0;
      nb = 1;
      pulse_hit(1, 10);
      expect_at("R1", before_mid(2), 1'b0, 0);
      expect_at("R1", after_mid(2), 1'b1, 10);
   endtask

   initial begin
      t_reset_state();
      t_sweep();
      t_hold();
      t_earliest();
      t_cross();
      t_mid_reset();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog (all requirements): actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end
endmodule